// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets a host reach a bank of 16-bit registers over a four-wire serial link. The link runs in mode 3 (clock idles high), most significant bit first, with fixed 16-bit frames. A frame is either a single-byte write or a read request. A read request is answered during the frame that follows it. That following frame can carry its own request, so a stream of reads stays fully pipelined.

The serial pins are sampled by the system clock through a short synchronizer, so the serial clock must be several times slower than the system clock. On the register side the block presents a word read address and takes the word back combinationally. Byte writes go out as a one-cycle strobe with a byte address and a data byte.

Three kinds of register are handled inside the block. A range of output words gets a new-data flag and an error flag merged into its top two bits. A diagnostic word holds sticky flags that a read clears. A command word holds request bits: a write sets them, and the completion pulses from the operations they start clear them.

Top module: `spi_regif`

## Requirements
- R1: Mode 3 timing: MOSI is sampled on SCLK rising edges and MISO shifts on SCLK falling edges, both MSB first. The response MSB appears after CS falls, and the first falling SCLK edge of a frame does not shift.
- R2: Frame bit 15 selects a write when 1, bits 14:8 are the byte address, and bits 7:0 are the data byte. A completed write frame raises `wr_stb` for one cycle with `wr_addr` and `wr_byte` after the 16th rising edge.
- R3: A write frame changes one byte only: it gives exactly one strobe, so a full word needs two frames.
- R4: Word w sits at byte addresses 2w and 2w+1. A read request to either address returns all 16 bits of word w, and `reg_raddr` carries w.
- R5: The answer to a read request is shifted out in the next frame. If the previous frame was a write, an incomplete frame, or there was none since reset, the next frame returns 0x0000.
- R6: `spi_miso_oe` is 0 while CS is high and 1 during a frame, and `spi_miso` is 0 whenever `spi_miso_oe` is 0.
- R7: An output word (word OUT_FIRST to OUT_FIRST+NUM_OUT-1) is returned as {new-data, error, reg_rdata[13:0]}. The error bit is 1 when any diagnostic flag is set.
- R8: The diagnostic word (word DIAG_WORD) is returned as its flags in the low bits, and returning it clears them. A `diag_set` pulse in the same cycle wins.
- R9: A write to the command low byte (byte 2*CMD_WORD) ORs the data into `cmd_req` and gives no `wr_stb`. A bit drops when its `cmd_done` pulses. Writes to the command high byte or to the diagnostic word change nothing and give no `wr_stb`.
- R10: An output word's new-data flag is set by its `out_load` pulse and cleared when that word is returned. A load in the same cycle wins.
- R11: If CS rises before 16 bits arrive, the frame is dropped: there is no strobe, no pending read, and the bit counter resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Drive enable for spi_miso |
| reg_raddr | output | 6 | Word address of pending read |
| reg_rdata | input | 16 | Register word at reg_raddr |
| wr_stb | output | 1 | One-cycle byte write strobe |
| wr_addr | output | 7 | Byte address of the write |
| wr_byte | output | 8 | Data byte of the write |
| out_load | input | NUM_OUT | Fresh-sample pulse per output word |
| diag_set | input | DIAG_W | Diagnostic flag set pulses |
| cmd_req | output | CMD_W | Pending command bits |
| cmd_done | input | CMD_W | Command completion pulses |

## Verification
The bench builds the block with OUT_FIRST=2, NUM_OUT=3 and DIAG_W=4, and keeps DIAG_WORD=28 and CMD_WORD=29. With these values word 2 is an output word, while words 0, 10 and 11 are plain words. The bench can therefore compare flag-merged and unmerged responses in the same read stream. It can also test the diagnostic and command words at both of their byte addresses. A narrow diagnostic field makes the returned flag value easy to predict exactly.

// File: rtl/spi_regif.sv
`timescale 1ns/1ps
module spi_regif #(
  parameter int OUT_FIRST = 1,
  parameter int NUM_OUT   = 6,
  parameter int DIAG_WORD = 28,
  parameter int CMD_WORD  = 29,
  parameter int DIAG_W    = 8,
  parameter int CMD_W     = 8,
  parameter int SYNC      = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_cs_n,
  input  logic               spi_sclk,
  input  logic               spi_mosi,
  output logic               spi_miso,
  output logic               spi_miso_oe,
  output logic [5:0]         reg_raddr,
  input  logic [15:0]        reg_rdata,
  output logic               wr_stb,
  output logic [6:0]         wr_addr,
  output logic [7:0]         wr_byte,
  input  logic [NUM_OUT-1:0] out_load,
  input  logic [DIAG_W-1:0]  diag_set,
  output logic [CMD_W-1:0]   cmd_req,
  input  logic [CMD_W-1:0]   cmd_done
);
  localparam int WAW = 6;
  localparam logic [WAW-1:0] DIAG_A = WAW'(DIAG_WORD);
  localparam logic [WAW-1:0] CMD_A  = WAW'(CMD_WORD);

  logic [SYNC:0]   cs_p, sck_p;
  logic [SYNC-1:0] dat_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p  <= '1;
      sck_p <= '1;
      dat_p <= '0;
    end else begin
      cs_p  <= {cs_p[SYNC-1:0], spi_cs_n};
      sck_p <= {sck_p[SYNC-1:0], spi_sclk};
      dat_p <= {dat_p[SYNC-2:0], spi_mosi};
    end

  logic cs_s, cs_fall, sck_rise, sck_fall, din_s;
  assign cs_s     = cs_p[SYNC-1];
  assign cs_fall  = cs_p[SYNC] & ~cs_s;
  assign sck_rise = ~sck_p[SYNC] & sck_p[SYNC-1] & ~cs_s;
  assign sck_fall = sck_p[SYNC] & ~sck_p[SYNC-1] & ~cs_s;
  assign din_s    = dat_p[SYNC-1];

  logic [4:0]  bitcnt;
  logic [14:0] rx;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt <= '0;
      rx     <= '0;
    end else if (cs_s) begin
      bitcnt <= '0;
    end else if (sck_rise && bitcnt != 5'd16) begin
      rx     <= {rx[13:0], din_s};
      bitcnt <= bitcnt + 5'd1;
    end

  logic           frame_done, f_wr, cmd_hit, diag_hit;
  logic [15:0]    frame;
  logic [WAW-1:0] f_word;
  assign frame      = {rx, din_s};
  assign frame_done = sck_rise && bitcnt == 5'd15;
  assign f_wr       = frame[15];
  assign f_word     = frame[14:9];
  assign cmd_hit    = f_word == CMD_A;
  assign diag_hit   = f_word == DIAG_A;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_byte <= '0;
    end else begin
      wr_stb <= frame_done && f_wr && !cmd_hit && !diag_hit;
      if (frame_done && f_wr) begin
        wr_addr <= frame[14:8];
        wr_byte <= frame[7:0];
      end
    end

  logic [CMD_W-1:0] cmd_set;
  assign cmd_set = (frame_done && f_wr && cmd_hit && !frame[8]) ? frame[CMD_W-1:0] : '0;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cmd_req <= '0;
    else        cmd_req <= (cmd_req & ~cmd_done) | cmd_set;

  logic           pend_v;
  logic [WAW-1:0] pend_w;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_w <= '0;
    end else if (frame_done) begin
      pend_v <= !f_wr;
      pend_w <= f_word;
    end else if (cs_fall) begin
      pend_v <= 1'b0;
    end
  assign reg_raddr = pend_w;

  logic               cap, diag_sel;
  logic [NUM_OUT-1:0] out_sel, nd;
  logic [DIAG_W-1:0]  diag;
  assign cap      = cs_fall && pend_v;
  assign diag_sel = pend_v && pend_w == DIAG_A;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    localparam logic [WAW-1:0] W = WAW'(OUT_FIRST + i);
    assign out_sel[i] = pend_v && pend_w == W;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) nd[i] <= 1'b0;
      else        nd[i] <= out_load[i] | (nd[i] & ~(cap & out_sel[i]));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) diag <= '0;
    else        diag <= diag_set | (diag & ~{DIAG_W{cap && diag_sel}});

  logic [15:0] resp;
  always_comb begin
    if (!pend_v)             resp = '0;
    else if (|out_sel)       resp = {|(out_sel & nd), |diag, reg_rdata[13:0]};
    else if (diag_sel)       resp = {{(16-DIAG_W){1'b0}}, diag};
    else if (pend_w == CMD_A) resp = '0;
    else                     resp = reg_rdata;
  end

  logic [15:0] sh;
  logic        oe_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh   <= '0;
      oe_q <= 1'b0;
    end else begin
      oe_q <= ~cs_s;
      if (cs_fall)                          sh <= resp;
      else if (sck_fall && bitcnt != 5'd0)  sh <= {sh[14:0], 1'b0};
    end
  assign spi_miso_oe = oe_q;
  assign spi_miso    = oe_q & sh[15];

  AST_WR_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> bitcnt == 5'd16); // R2
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R3
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> !spi_miso_oe); // R6
  AST_DIAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && diag_sel && !(|diag_set)) |=> diag == '0); // R8
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cmd_req) & ~$past(cmd_done) & ~cmd_req) == '0)); // R9
  AST_ND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_load) |=> ((nd & $past(out_load)) == $past(out_load))); // R10
endmodule

// File: tb/tb_spi_regif.sv
`timescale 1ns/1ps
module tb_spi_regif;
  localparam int NO = 3, DW = 4, CW = 8;
  logic clk = 0, rst_n = 0;
  logic spi_cs_n = 1, spi_sclk = 1, spi_mosi = 0;
  logic spi_miso, spi_miso_oe, wr_stb;
  logic [5:0] reg_raddr;
  logic [15:0] reg_rdata;
  logic [6:0] wr_addr;
  logic [7:0] wr_byte;
  logic [NO-1:0] out_load = '0;
  logic [DW-1:0] diag_set = '0;
  logic [CW-1:0] cmd_req, cmd_done = '0;
  logic [15:0] rf [64];
  int checks = 0, failures = 0, wcnt = 0;
  logic [6:0] last_wa;
  logic [7:0] last_wb;
  logic oe_seen, done = 0;
  logic [15:0] r;

  always #10 clk = ~clk;
  assign reg_rdata = rf[reg_raddr];

  spi_regif #(.OUT_FIRST(2), .NUM_OUT(NO), .DIAG_WORD(28), .CMD_WORD(29),
              .DIAG_W(DW), .CMD_W(CW)) dut (.*);

  always @(negedge clk) if (wr_stb) begin
    wcnt++; last_wa = wr_addr; last_wb = wr_byte;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] tx, input int nb, output logic [15:0] rxw);
    rxw = '0;
    spi_cs_n = 0;
    repeat (6) @(negedge clk);
    oe_seen = spi_miso_oe;
    for (int i = 0; i < nb; i++) begin
      spi_sclk = 0; spi_mosi = tx[15-i];
      repeat (8) @(negedge clk);
      rxw[15-i] = spi_miso;
      spi_sclk = 1;
      repeat (8) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    spi_cs_n = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R6 reset oe", {15'd0, spi_miso_oe}, 16'd0);
    chk("R9 reset cmd", {8'd0, cmd_req}, 16'd0);
  endtask

  task automatic t_pipeline;
    xfer(16'h1400, 16, r); chk("R5 first frame zero", r, 16'h0000);
    chk("R6 oe in frame", {15'd0, oe_seen}, 16'd1);
    xfer(16'h1600, 16, r); chk("R1 R4 word10 even", r, 16'hA5C3);
    xfer(16'h1700, 16, r); chk("R5 chained word11", r, 16'h3C96);
    xfer(16'h9A5C, 16, r); chk("R4 word11 odd", r, 16'h3C96);
    xfer(16'h0000, 16, r); chk("R5 after write", r, 16'h0000);
    chk("R2 write count", 16'(wcnt), 16'd1);
    chk("R2 write addr", {9'd0, last_wa}, 16'h001A);
    chk("R2 write byte", {8'd0, last_wb}, 16'h005C);
  endtask

  task automatic t_partial;
    xfer(16'h9B77, 8, r);
    xfer(16'h0000, 16, r); chk("R11 no pending after partial", r, 16'h0000);
    chk("R11 no strobe", 16'(wcnt), 16'd1);
  endtask

  task automatic t_words;
    xfer(16'h8011, 16, r); xfer(16'h8122, 16, r);
    chk("R3 two frames two strobes", 16'(wcnt), 16'd3);
    chk("R3 second byte addr", {9'd0, last_wa}, 16'h0001);
    chk("R3 second byte data", {8'd0, last_wb}, 16'h0022);
  endtask

  task automatic t_newdata;
    rf[2] = 16'hD234;
    @(negedge clk) out_load = 3'b001;
    @(negedge clk) out_load = '0;
    xfer(16'h0400, 16, r);
    xfer(16'h0500, 16, r); chk("R7 R10 fresh word", r, 16'h9234);
    xfer(16'h0000, 16, r); chk("R10 flag cleared", r, 16'h1234);
  endtask

  task automatic t_diag;
    @(negedge clk) diag_set = 4'b0100;
    @(negedge clk) diag_set = '0;
    xfer(16'h0400, 16, r);
    xfer(16'h3800, 16, r); chk("R7 error bit", r, 16'h5234);
    xfer(16'h3900, 16, r); chk("R8 diag flags", r, 16'h0004);
    xfer(16'h0400, 16, r); chk("R8 diag cleared", r, 16'h0000);
    xfer(16'h0000, 16, r); chk("R8 error gone", r, 16'h1234);
  endtask

  task automatic t_cmd;
    xfer(16'hBA05, 16, r);
    chk("R9 cmd set", {8'd0, cmd_req}, 16'h0005);
    chk("R9 cmd no strobe", 16'(wcnt), 16'd3);
    @(negedge clk) cmd_done = 8'h01;
    @(negedge clk) cmd_done = '0;
    chk("R9 cmd done clears", {8'd0, cmd_req}, 16'h0004);
    xfer(16'hBBFF, 16, r);
    chk("R9 high byte ignored", {8'd0, cmd_req}, 16'h0004);
    xfer(16'hB8FF, 16, r);
    chk("R9 diag write ignored", 16'(wcnt), 16'd3);
    xfer(16'h3800, 16, r); xfer(16'h0000, 16, r);
    chk("R9 diag unchanged", r, 16'h0000);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) rf[i] = '0;
    rf[0] = 16'h7E01; rf[10] = 16'hA5C3; rf[11] = 16'h3C96;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset;
    t_pipeline;
    t_partial;
    t_words;
    t_newdata;
    t_diag;
    t_cmd;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule